// File: doc/BRIEF.md
# Embedded Interval and Watchdog Timer Set

This block holds the three timers that sit beside an embedded processor core. A programmable down-counter raises an interrupt when it runs out and can reload itself. A fixed-interval event fires each time a chosen bit of the free-running time base goes from 0 to 1. A watchdog climbs one stage on each of its own period events: first it arms, then it interrupts, then it requests a reset of a configurable kind. The time base is an input and is not counted here.

Software reaches the block through a single write port with a 2-bit register select. Select 0 is the control register, select 1 is the status register and select 2 is the reload value of the down-counter. The current control word, the status word and the live down-counter value are always visible on output ports. The status register is write-one-to-clear, and it records which escalation stage the watchdog has reached and which reset it last issued.

Top module: `emb_timer_set`

## Requirements
- R1: After reset the control word, the status word, the counter value, all three interrupt requests and the reset request are zero. A write with select 0 stores only bits 31:22 of the data. Bits 21:0 of the control word always read zero.
- R2: A write with select 1 clears each status bit in 31:26 that is written as one. Bits 25:0 of the data have no effect. If a timer event sets a status bit in the same cycle as a write clears it, the bit ends up set.
- R3: A write with select 2 loads both the reload value and the count. The counter runs only if the loaded value is greater than 1 and the counter interrupt enable (control bit 26) is set. A running counter drops by one for each time-base advance, seen as a change of time-base bit 0.
- R4: When a running count passes from 1 to 0 the counter has expired. Expiry sets status bit 27. When control bit 26 is set, expiry also raises `pit_irq`, which stays high until status bit 31 is written as one.
- R5: When control bit 22 (auto-reload) is set at expiry, the count takes the reload value and keeps running. When bit 22 is clear, the count stays at 0 and the counter stops.
- R6: A control write that clears bit 26 stops the counter, and the count then holds its value.
- R7: The interval event fires on a 0-to-1 transition of time-base bit FIT_BASE + FIT_STEP*s, where s is control bits 25:24. The event sets status bit 26. When control bit 23 is set, the event also raises `fit_irq`, which stays high until status bit 26 is written as one.
- R8: The watchdog event fires on a 0-to-1 transition of time-base bit WDT_BASE + WDT_STEP*w, where w is control bits 31:30. On each event the watchdog does one of three things. With status bit 31 clear, it sets bit 31. With bit 31 set and bit 30 clear, it sets bit 30 and raises `wdt_irq` if control bit 27 is set. With both bits set, it takes the reset step.
- R9: In the reset step, control bits 29:28 are copied into status bits 29:28. When that code is non-zero, `rst_req` pulses for one cycle with `rst_type` equal to the code: 1 = core, 2 = chip, 3 = system. Code 0 records 0 and requests nothing.
- R10: `wdt_irq` stays high until status bit 30 is written as one.
- R11: A write with select 3 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb | input | TB_W | Free-running time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 status, 2 counter reload, 3 none |
| wr_data | input | 32 | Write data |
| ctrl_o | output | 32 | Current control word |
| stat_o | output | 32 | Current status word |
| pit_o | output | PIT_W | Current down-counter value |
| pit_irq | output | 1 | Down-counter interrupt request |
| fit_irq | output | 1 | Fixed-interval interrupt request |
| wdt_irq | output | 1 | Watchdog interrupt request |
| rst_req | output | 1 | One-cycle reset request |
| rst_type | output | 2 | Kind of reset requested with `rst_req` |

## Verification
The bench builds the block with a 16-bit time base and an 8-bit counter. It sets the interval taps to bits 1 to 4 and the watchdog taps to bits 3, 5, 7 and 9. With these values every period select, and all three watchdog stages for every reset code, are reached in a few dozen cycles by writing chosen time-base values directly. Driving the time base one step per cycle makes each counter decrement and each expiry fall on a known clock edge. The same edge can carry a status clear, so the bench can check what happens when both arrive together.

// File: rtl/emb_tmr_pkg.sv
package emb_tmr_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PIT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    RST_NONE = 2'd0,
    RST_CORE = 2'd1,
    RST_CHIP = 2'd2,
    RST_SYS  = 2'd3
  } rst_kind_e;

  // control word field positions (lsb of multi-bit fields)
  localparam int CB_WPER = 30;
  localparam int CB_WRC  = 28;
  localparam int CB_WIE  = 27;
  localparam int CB_PIE  = 26;
  localparam int CB_FPER = 24;
  localparam int CB_FIE  = 23;
  localparam int CB_ARE  = 22;

  // status word field positions
  localparam int SB_WNEXT = 31;
  localparam int SB_WINT  = 30;
  localparam int SB_WRST  = 28;
  localparam int SB_PIT   = 27;
  localparam int SB_FIT   = 26;

  localparam logic [31:0] CTRL_KEEP = 32'hFFC0_0000;
  localparam logic [31:0] STAT_W1C  = 32'hFC00_0000;

  typedef struct packed {
    logic set_next;
    logic set_int;
    logic fire_rst;
  } wdog_act_t;

  // time-base bit watched for a given period select
  function automatic int tap_index(int base, int step, int sel);
    return base + step * sel;
  endfunction

  // one watchdog escalation step from the current stage bits
  function automatic wdog_act_t wdog_step(logic armed, logic intr);
    wdog_act_t a;
    a.set_next = !armed;
    a.set_int  = armed && !intr;
    a.fire_rst = armed && intr;
    return a;
  endfunction

endpackage

// File: rtl/emb_tb_tap.sv
module emb_tb_tap
  import emb_tmr_pkg::*;
#(
  parameter int TB_W = 64,
  parameter int BASE = 9,
  parameter int STEP = 4
) (
  input  logic [TB_W-1:0] tb,
  input  logic [TB_W-1:0] tb_prev,
  input  logic [1:0]      sel,
  output logic            rise
);

  logic [3:0] hit;

  for (genvar k = 0; k < 4; k++) begin : g_tap
    localparam int IDX = tap_index(BASE, STEP, k);
    assign hit[k] = tb[IDX] & ~tb_prev[IDX];
  end

  assign rise = hit[sel];

endmodule

// File: rtl/emb_pit.sv
module emb_pit #(
  parameter int PIT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [PIT_W-1:0] ld_val,
  input  logic             ctl_wr,
  input  logic             pie_nxt,
  input  logic             pie,
  input  logic             are,
  input  logic             tick,
  output logic [PIT_W-1:0] count_o,
  output logic [PIT_W-1:0] reload_o,
  output logic             run_o,
  output logic             expire_o
);

  localparam logic [PIT_W-1:0] ONE = PIT_W'(1);

  logic [PIT_W-1:0] count_q, reload_q;
  logic             run_q;
  logic             stop_req;

  function automatic logic can_run(logic [PIT_W-1:0] v, logic en);
    return en && (v > ONE);
  endfunction

  assign stop_req = ctl_wr && !can_run(reload_q, pie_nxt);
  assign expire_o = run_q && tick && !ld && !stop_req && (count_q <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      run_q    <= 1'b0;
    end else if (ld) begin
      reload_q <= ld_val;
      count_q  <= ld_val;
      run_q    <= can_run(ld_val, pie);
    end else if (stop_req) begin
      run_q <= 1'b0;
    end else if (run_q && tick) begin
      if (count_q <= ONE) begin
        if (are) begin
          count_q <= reload_q;
        end else begin
          count_q <= '0;
          run_q   <= 1'b0;
        end
      end else begin
        count_q <= count_q - ONE;
      end
    end
  end

  assign count_o  = count_q;
  assign reload_o = reload_q;
  assign run_o    = run_q;

endmodule

// File: rtl/emb_wdog.sv
module emb_wdog
  import emb_tmr_pkg::*;
(
  input  logic       ev,
  input  logic       armed,
  input  logic       intr,
  input  logic       wie,
  input  logic [1:0] rc,
  output logic       set_next,
  output logic       set_int,
  output logic       irq_set,
  output logic       fire,
  output logic       rst_fire
);

  wdog_act_t act;

  assign act      = wdog_step(armed, intr);
  assign set_next = ev && act.set_next;
  assign set_int  = ev && act.set_int;
  assign irq_set  = set_int && wie;
  assign fire     = ev && act.fire_rst;
  assign rst_fire = fire && (rst_kind_e'(rc) != RST_NONE);

endmodule

// File: rtl/emb_timer_set.sv
module emb_timer_set
  import emb_tmr_pkg::*;
#(
  parameter int TB_W     = 64,
  parameter int PIT_W    = 32,
  parameter int FIT_BASE = 9,
  parameter int FIT_STEP = 4,
  parameter int WDT_BASE = 17,
  parameter int WDT_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  tb,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic [31:0]      ctrl_o,
  output logic [31:0]      stat_o,
  output logic [PIT_W-1:0] pit_o,
  output logic             pit_irq,
  output logic             fit_irq,
  output logic             wdt_irq,
  output logic             rst_req,
  output logic [1:0]       rst_type
);

  logic [31:0]     ctrl_q, stat_q, stat_n, stat_clr, ctrl_d;
  logic [TB_W-1:0] tb_prev;
  logic            wr_ctrl, wr_stat, wr_pit;
  logic            pie_nxt, tick;
  logic            fit_ev, wdt_ev;
  logic            pit_exp, pit_run;
  logic [PIT_W-1:0] pit_reload;
  logic            w_next, w_int, w_irq, w_fire, w_rst;
  logic            pit_irq_q, fit_irq_q, wdt_irq_q, rst_req_q;
  logic [1:0]      rst_type_q;

  assign wr_ctrl  = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL);
  assign wr_stat  = wr_en && (reg_sel_e'(wr_addr) == SEL_STAT);
  assign wr_pit   = wr_en && (reg_sel_e'(wr_addr) == SEL_PIT);
  assign ctrl_d   = wr_data & CTRL_KEEP;
  assign stat_clr = wr_stat ? (wr_data & STAT_W1C) : '0;
  assign pie_nxt  = wr_ctrl ? ctrl_d[CB_PIE] : ctrl_q[CB_PIE];
  assign tick     = tb[0] ^ tb_prev[0];

  emb_tb_tap #(.TB_W(TB_W), .BASE(FIT_BASE), .STEP(FIT_STEP)) u_fit_tap (
    .tb      (tb),
    .tb_prev (tb_prev),
    .sel     (ctrl_q[CB_FPER +: 2]),
    .rise    (fit_ev)
  );

  emb_tb_tap #(.TB_W(TB_W), .BASE(WDT_BASE), .STEP(WDT_STEP)) u_wdt_tap (
    .tb      (tb),
    .tb_prev (tb_prev),
    .sel     (ctrl_q[CB_WPER +: 2]),
    .rise    (wdt_ev)
  );

  emb_pit #(.PIT_W(PIT_W)) u_pit (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (wr_pit),
    .ld_val   (wr_data[PIT_W-1:0]),
    .ctl_wr   (wr_ctrl),
    .pie_nxt  (pie_nxt),
    .pie      (ctrl_q[CB_PIE]),
    .are      (ctrl_q[CB_ARE]),
    .tick     (tick),
    .count_o  (pit_o),
    .reload_o (pit_reload),
    .run_o    (pit_run),
    .expire_o (pit_exp)
  );

  emb_wdog u_wdog (
    .ev       (wdt_ev),
    .armed    (stat_q[SB_WNEXT]),
    .intr     (stat_q[SB_WINT]),
    .wie      (ctrl_q[CB_WIE]),
    .rc       (ctrl_q[CB_WRC +: 2]),
    .set_next (w_next),
    .set_int  (w_int),
    .irq_set  (w_irq),
    .fire     (w_fire),
    .rst_fire (w_rst)
  );

  // clears first, then events: a same-cycle event leaves its bit set
  always_comb begin
    stat_n = stat_q & ~stat_clr;
    if (pit_exp) stat_n[SB_PIT]   = 1'b1;
    if (fit_ev)  stat_n[SB_FIT]   = 1'b1;
    if (w_next)  stat_n[SB_WNEXT] = 1'b1;
    if (w_int)   stat_n[SB_WINT]  = 1'b1;
    if (w_fire)  stat_n[SB_WRST +: 2] = ctrl_q[CB_WRC +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      stat_q     <= '0;
      tb_prev    <= '0;
      pit_irq_q  <= 1'b0;
      fit_irq_q  <= 1'b0;
      wdt_irq_q  <= 1'b0;
      rst_req_q  <= 1'b0;
      rst_type_q <= 2'b00;
    end else begin
      tb_prev <= tb;
      stat_q  <= stat_n;
      if (wr_ctrl) ctrl_q <= ctrl_d;

      if (pit_exp && ctrl_q[CB_PIE])       pit_irq_q <= 1'b1;
      else if (stat_clr[SB_WNEXT])         pit_irq_q <= 1'b0;

      if (fit_ev && ctrl_q[CB_FIE])        fit_irq_q <= 1'b1;
      else if (stat_clr[SB_FIT])           fit_irq_q <= 1'b0;

      if (w_irq)                           wdt_irq_q <= 1'b1;
      else if (stat_clr[SB_WINT])          wdt_irq_q <= 1'b0;

      rst_req_q  <= w_rst;
      rst_type_q <= w_rst ? ctrl_q[CB_WRC +: 2] : 2'b00;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign stat_o   = stat_q;
  assign pit_irq  = pit_irq_q;
  assign fit_irq  = fit_irq_q;
  assign wdt_irq  = wdt_irq_q;
  assign rst_req  = rst_req_q;
  assign rst_type = rst_type_q;

endmodule

// File: rtl/emb_timer_set_chk.sv
module emb_timer_set_chk #(
  parameter int PIT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      ctrl_o,
  input logic [31:0]      stat_o,
  input logic             pit_run,
  input logic [PIT_W-1:0] pit_reload,
  input logic             pit_irq,
  input logic             fit_irq,
  input logic             wdt_irq,
  input logic             rst_req,
  input logic [1:0]       rst_type
);

  AST_PIT_RUN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pit_run |-> (pit_reload > PIT_W'(1)) && ctrl_o[26]); // R3

  AST_PIT_IRQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pit_irq) |-> stat_o[27]); // R4

  AST_FIT_IRQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fit_irq) |-> stat_o[26]); // R7

  AST_WDT_ESCALATE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[30]) |-> $past(stat_o[31])); // R8

  AST_RST_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (stat_o[29:28] == rst_type) && (rst_type != 2'b00)); // R9

  AST_WDT_IRQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_irq) |-> stat_o[30]); // R10

endmodule

bind emb_timer_set emb_timer_set_chk #(.PIT_W(PIT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_o     (ctrl_o),
  .stat_o     (stat_o),
  .pit_run    (pit_run),
  .pit_reload (pit_reload),
  .pit_irq    (pit_irq),
  .fit_irq    (fit_irq),
  .wdt_irq    (wdt_irq),
  .rst_req    (rst_req),
  .rst_type   (rst_type)
);

// File: tb/emb_timer_set_tb_top.sv
module emb_timer_set_tb_top;

  localparam int TBW = 16;
  localparam int PW  = 8;

  localparam logic [31:0] PIE = 32'h0400_0000;
  localparam logic [31:0] ARE = 32'h0040_0000;
  localparam logic [31:0] FIE = 32'h0080_0000;
  localparam logic [31:0] WIE = 32'h0800_0000;
  localparam logic [31:0] CLR_ALL = 32'hFC00_0000;

  // interval table: period select -> watched time-base bit (base 1, step 1)
  localparam int FIT_BIT [4] = '{1, 2, 3, 4};
  // watchdog table: {period select, reset code, interrupt enable}
  localparam logic [4:0] WDT_VEC [4] = '{5'b00_01_1, 5'b01_10_0, 5'b10_11_1, 5'b11_00_1};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [TBW-1:0]  tb_r = '0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_addr = 2'd0;
  logic [31:0]     wr_data = '0;
  logic [31:0]     ctrl_o, stat_o;
  logic [PW-1:0]   pit_o;
  logic            pit_irq, fit_irq, wdt_irq, rst_req;
  logic [1:0]      rst_type;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  emb_timer_set #(
    .TB_W(TBW), .PIT_W(PW), .FIT_BASE(1), .FIT_STEP(1), .WDT_BASE(3), .WDT_STEP(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tb(tb_r), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_o(ctrl_o), .stat_o(stat_o), .pit_o(pit_o),
    .pit_irq(pit_irq), .fit_irq(fit_irq), .wdt_irq(wdt_irq),
    .rst_req(rst_req), .rst_type(rst_type)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_tb(input int v);
    @(negedge clk);
    tb_r = TBW'(v);
    @(negedge clk);
  endtask

  task automatic step_tb();
    set_tb(int'(tb_r) + 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl reset", ctrl_o, 32'h0);
    chk("R1 stat reset", stat_o, 32'h0);
    chk("R1 pit reset", 32'(pit_o), 32'h0);
    chk("R1 outputs reset", {27'h0, pit_irq, fit_irq, wdt_irq, rst_req, 1'b0}, 32'h0);

    // R1 control mask
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R1 ctrl keeps 31:22", ctrl_o, 32'hFFC0_0000);
    wr(2'd0, 32'h0);
    wr(2'd1, CLR_ALL);

    // R11 select 3 ignored
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R11 ctrl untouched", ctrl_o, 32'h0);
    chk("R11 stat untouched", stat_o, 32'h0);
    chk("R11 pit untouched", 32'(pit_o), 32'h0);

    // R3 R4 one-shot down-counter
    wr(2'd0, PIE);
    wr(2'd2, 32'd3);
    chk("R3 load count", 32'(pit_o), 32'd3);
    step_tb(); chk("R3 decrement", 32'(pit_o), 32'd2);
    step_tb(); chk("R3 decrement", 32'(pit_o), 32'd1);
    step_tb();
    chk("R5 no reload stays 0", 32'(pit_o), 32'd0);
    chk("R4 status bit 27", 32'(stat_o[27]), 32'd1);
    chk("R4 pit_irq raised", 32'(pit_irq), 32'd1);
    step_tb(); chk("R5 stopped at 0", 32'(pit_o), 32'd0);
    wr(2'd1, 32'h8000_0000);
    chk("R4 pit_irq cleared by bit31", 32'(pit_irq), 32'd0);
    chk("R4 bit27 kept", 32'(stat_o[27]), 32'd1);
    wr(2'd1, 32'h0800_0000 | 32'h03FF_FFFF);
    chk("R2 w1c bit27, low bits no effect", stat_o & 32'h0BFF_FFFF, 32'h0);

    // R5 auto-reload
    wr(2'd0, PIE | ARE);
    wr(2'd2, 32'd2);
    step_tb(); chk("R5 decrement", 32'(pit_o), 32'd1);
    step_tb();
    chk("R5 reload at expiry", 32'(pit_o), 32'd2);
    chk("R5 expiry status", 32'(stat_o[27]), 32'd1);
    step_tb(); chk("R5 keeps running", 32'(pit_o), 32'd1);

    // R6 clearing enable freezes the count
    wr(2'd0, ARE);
    step_tb(); step_tb();
    chk("R6 count frozen", 32'(pit_o), 32'd1);

    // R3 boundary: value 1 never runs
    wr(2'd0, PIE);
    wr(2'd1, CLR_ALL);
    wr(2'd2, 32'd1);
    step_tb(); step_tb();
    chk("R3 value 1 does not run", 32'(pit_o), 32'd1);
    chk("R3 value 1 no expiry", 32'(stat_o[27]), 32'd0);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'd5);
    step_tb();
    chk("R3 enable clear does not run", 32'(pit_o), 32'd5);

    // R7 interval table walk
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, FIE | (32'(i) << 24));
      set_tb((1 << FIT_BIT[i]) - 1);
      wr(2'd1, CLR_ALL);
      chk("R7 no event below tap", 32'(stat_o[26]), 32'd0);
      set_tb(1 << FIT_BIT[i]);
      chk("R7 tap status", 32'(stat_o[26]), 32'd1);
      chk("R7 tap irq", 32'(fit_irq), 32'd1);
    end
    wr(2'd1, 32'h0400_0000);
    chk("R7 fit_irq cleared by bit26", 32'(fit_irq), 32'd0);
    wr(2'd0, 32'h0);
    set_tb(0);
    wr(2'd1, CLR_ALL);
    set_tb(2);
    chk("R7 status without enable", 32'(stat_o[26]), 32'd1);
    chk("R7 no irq without enable", 32'(fit_irq), 32'd0);

    // R2 event and clear in the same cycle: event wins
    set_tb(0);
    @(negedge clk);
    tb_r = TBW'(2); wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h0400_0000;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 event wins over clear", 32'(stat_o[26]), 32'd1);

    // R8 R9 R10 watchdog escalation table
    for (int i = 0; i < 4; i++) begin
      logic [1:0] sel, code;
      logic       ie;
      int         wb;
      {sel, code, ie} = WDT_VEC[i];
      wb = 3 + 2 * int'(sel);
      wr(2'd0, (32'(sel) << 30) | (32'(code) << 28) | (ie ? WIE : 32'h0));
      set_tb((1 << wb) - 1);
      wr(2'd1, CLR_ALL);
      set_tb(1 << wb);
      chk("R8 stage arm", 32'(stat_o[31:30]), 32'd2);
      chk("R8 no irq on arm", 32'(wdt_irq), 32'd0);
      set_tb(0);
      set_tb(1 << wb);
      chk("R8 stage interrupt", 32'(stat_o[31:30]), 32'd3);
      chk("R8 wdt_irq follows enable", 32'(wdt_irq), 32'(ie));
      set_tb(0);
      set_tb(1 << wb);
      chk("R9 reset request", 32'(rst_req), 32'(code != 2'b00));
      chk("R9 reset type", 32'(rst_type), 32'(code));
      chk("R9 recorded type", 32'(stat_o[29:28]), 32'(code));
      @(negedge clk);
      chk("R9 single-cycle pulse", 32'(rst_req), 32'd0);
      wr(2'd1, 32'h4000_0000);
      chk("R10 wdt_irq cleared by bit30", 32'(wdt_irq), 32'd0);
    end

    done = 1'b1;
    summary();
  end

endmodule